// File: doc/BRIEF.md
# Grouped Priority Interrupt Selector

This block looks at 68 maskable interrupt lines and chooses the one to serve next. A line can be chosen only when its pending bit and its enable bit are both set. Each line has an 8-bit priority byte. Only the upper four bits of that byte are implemented, and a smaller number means a more urgent line. A 3-bit grouping control divides that 4-bit value into a group field (upper part) and a subpriority field (lower part).

The comparison uses the group field first, then the subpriority, then the line number, where the lower number wins. The block reports the chosen line, a valid flag, and the chosen line's group and subpriority values under the current grouping. All outputs are registered, so they follow the inputs with one clock of latency. A surrounding controller uses these outputs to make preemption decisions and to fetch handler addresses. Those tasks are not part of this block.

Top module: `prio_arb`

## Requirements
- R1: A line is a candidate only when bit i of `irq_pend_i` and bit i of `irq_en_i` are both 1. When no line is a candidate, `win_vld_o` is 0 and `win_id_o`, `win_grp_o` and `win_sub_o` are all 0.
- R2: Among candidates, the line with the smallest group field wins.
- R3: Among candidates that share the smallest group field, the line with the smallest subpriority wins.
- R4: When candidates are equal in both group field and subpriority, the line with the lowest number wins.
- R5: Only bits [7:4] of each priority byte take part in selection. Bits [3:0] have no effect on any output.
- R6: The grouping control g sets the number of subpriority bits s. If g is 3 or below, s = 0. If g is 4 to 7, s = g - 3. The group output is the 4-bit priority shifted right by s. The subpriority output is the low s bits of the priority.
- R7: Outputs are registered. While `rst_n` is low they are all 0. After an input change they update at the next rising clock edge and not before.
- R8: Line i uses bit i of the pending and enable vectors and the byte `prio_i[8i+7:8i]`. When line i wins, `win_id_o` reports i, in the range 0 to 67.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| grp_ctl_i | input | 3 | Grouping control that sets the group/subpriority split |
| irq_pend_i | input | 68 | Pending bit per line |
| irq_en_i | input | 68 | Enable bit per line |
| prio_i | input | 544 | Priority byte per line; line i at bits [8i+7:8i] |
| win_vld_o | output | 1 | At least one candidate existed on the previous cycle |
| win_id_o | output | 7 | Number of the winning line |
| win_grp_o | output | 4 | Group field of the winner |
| win_sub_o | output | 4 | Subpriority field of the winner |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that reset is released in step with the clock, so one captured input set is followed by exactly one output update. The checker keeps its own copy of the previous grouping control and its own reference winner, so the grouping control may change in any cycle. The stimulus changes every input only at the falling clock edge and never leaves a bit unknown. It covers empty, sparse and dense candidate sets under all eight grouping values.

// File: rtl/prio_arb_pkg.sv
`timescale 1ns/1ps
package prio_arb_pkg;
  localparam int IRQ_CNT     = 68;
  localparam int PRIO_BYTE_W = 8;
  localparam int PRIO_W      = 4;
  localparam int GRP_CTL_W   = 3;
  localparam int ID_W        = $clog2(IRQ_CNT);
  localparam int TREE_LVL    = $clog2(IRQ_CNT);
  localparam int LEAF_CNT    = 1 << TREE_LVL;
  // grouping value above which subpriority bits start to appear
  localparam int SPLIT_BASE  = (1 << GRP_CTL_W) - 1 - PRIO_W;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] key;
    logic [ID_W-1:0]   id;
  } cand_t;
endpackage

// File: rtl/prio_arb_pick.sv
`timescale 1ns/1ps
module prio_arb_pick
  import prio_arb_pkg::*;
(
  input  cand_t lo_i,
  input  cand_t hi_i,
  output cand_t win_o
);
  // lo_i always covers lower line numbers, so it keeps ties
  always_comb begin
    if (lo_i.vld && (!hi_i.vld || (lo_i.key <= hi_i.key))) begin
      win_o = lo_i;
    end else begin
      win_o = hi_i;
    end
  end
endmodule

// File: rtl/prio_arb_tree.sv
`timescale 1ns/1ps
module prio_arb_tree
  import prio_arb_pkg::*;
(
  input  cand_t cand_i [IRQ_CNT],
  output cand_t best_o
);
  localparam int NODE_CNT = 2 * LEAF_CNT - 1;

  // heap layout: node 0 is the root, leaves start at LEAF_CNT-1
  cand_t node [NODE_CNT];

  for (genvar k = 0; k < LEAF_CNT; k++) begin : g_leaf
    if (k < IRQ_CNT) begin : g_real
      assign node[LEAF_CNT-1+k] = cand_i[k];
    end else begin : g_pad
      assign node[LEAF_CNT-1+k] = '{vld: 1'b0, key: '0, id: ID_W'(k)};
    end
  end

  for (genvar n = 0; n < LEAF_CNT - 1; n++) begin : g_node
    prio_arb_pick u_pick (
      .lo_i  (node[2*n+1]),
      .hi_i  (node[2*n+2]),
      .win_o (node[n])
    );
  end

  assign best_o = node[0];
endmodule

// File: rtl/prio_arb_split.sv
`timescale 1ns/1ps
module prio_arb_split
  import prio_arb_pkg::*;
(
  input  logic [PRIO_W-1:0]    key_i,
  input  logic [GRP_CTL_W-1:0] grp_ctl_i,
  output logic [PRIO_W-1:0]    grp_o,
  output logic [PRIO_W-1:0]    sub_o
);
  localparam logic [GRP_CTL_W-1:0] BASE_C = GRP_CTL_W'(SPLIT_BASE);

  logic [GRP_CTL_W-1:0] sub_bits;
  logic [PRIO_W-1:0]    sub_mask;

  always_comb begin
    sub_bits = (grp_ctl_i > BASE_C) ? (grp_ctl_i - BASE_C) : '0;
    // a shift of PRIO_W wraps to zero, so the mask becomes all ones
    sub_mask = (PRIO_W'(1) << sub_bits) - PRIO_W'(1);
    grp_o    = key_i >> sub_bits;
    sub_o    = key_i & sub_mask;
  end
endmodule

// File: rtl/prio_arb.sv
`timescale 1ns/1ps
module prio_arb
  import prio_arb_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [GRP_CTL_W-1:0]           grp_ctl_i,
  input  logic [IRQ_CNT-1:0]             irq_pend_i,
  input  logic [IRQ_CNT-1:0]             irq_en_i,
  input  logic [IRQ_CNT*PRIO_BYTE_W-1:0] prio_i,
  output logic                           win_vld_o,
  output logic [ID_W-1:0]                win_id_o,
  output logic [PRIO_W-1:0]              win_grp_o,
  output logic [PRIO_W-1:0]              win_sub_o
);
  localparam int LOW_W = PRIO_BYTE_W - PRIO_W;

  cand_t             cand [IRQ_CNT];
  cand_t             best;
  logic [PRIO_W-1:0] split_grp;
  logic [PRIO_W-1:0] split_sub;
  logic [IRQ_CNT-1:0] low_par;
  logic              low_bits_unused;

  for (genvar k = 0; k < IRQ_CNT; k++) begin : g_cand
    assign cand[k] = '{
      vld: irq_pend_i[k] & irq_en_i[k],
      key: prio_i[k*PRIO_BYTE_W + PRIO_BYTE_W-1 -: PRIO_W],
      id:  ID_W'(k)
    };
    assign low_par[k] = ^prio_i[k*PRIO_BYTE_W +: LOW_W];
  end
  assign low_bits_unused = ^low_par;

  prio_arb_tree u_tree (
    .cand_i (cand),
    .best_o (best)
  );

  prio_arb_split u_split (
    .key_i     (best.key),
    .grp_ctl_i (grp_ctl_i),
    .grp_o     (split_grp),
    .sub_o     (split_sub)
  );

  logic              upd_en;
  logic              vld_d;
  logic [ID_W-1:0]   id_d;
  logic [PRIO_W-1:0] grp_d;
  logic [PRIO_W-1:0] sub_d;

  assign upd_en = 1'b1;

  always_comb begin
    vld_d = best.vld;
    id_d  = '0;
    grp_d = '0;
    sub_d = '0;
    if (best.vld) begin
      id_d  = best.id;
      grp_d = split_grp;
      sub_d = split_sub;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_vld_o <= 1'b0;
      win_id_o  <= '0;
      win_grp_o <= '0;
      win_sub_o <= '0;
    end else if (upd_en) begin
      win_vld_o <= vld_d;
      win_id_o  <= id_d;
      win_grp_o <= grp_d;
      win_sub_o <= sub_d;
    end
  end
endmodule

// File: rtl/prio_arb_chk.sv
`timescale 1ns/1ps
module prio_arb_chk
  import prio_arb_pkg::*;
(
  input logic                           clk,
  input logic                           rst_n,
  input logic [GRP_CTL_W-1:0]           grp_ctl_i,
  input logic [IRQ_CNT-1:0]             irq_pend_i,
  input logic [IRQ_CNT-1:0]             irq_en_i,
  input logic [IRQ_CNT*PRIO_BYTE_W-1:0] prio_i,
  input logic                           win_vld_o,
  input logic [ID_W-1:0]                win_id_o,
  input logic [PRIO_W-1:0]              win_grp_o,
  input logic [PRIO_W-1:0]              win_sub_o
);
  logic              ref_vld, ref_vld_q;
  logic [PRIO_W-1:0] ref_key, ref_key_q;
  logic [ID_W-1:0]   ref_id, ref_id_q;
  logic [GRP_CTL_W-1:0] grp_q;
  logic [GRP_CTL_W-1:0] sb_q;
  logic              past_ok;
  logic              chk_low_unused;

  assign chk_low_unused = ^prio_i;

  // straight scan, strict less-than keeps the lowest line on ties
  always_comb begin
    ref_vld = 1'b0;
    ref_key = '1;
    ref_id  = '0;
    for (int i = 0; i < IRQ_CNT; i++) begin
      if (irq_pend_i[i] && irq_en_i[i] &&
          (!ref_vld || (prio_i[i*PRIO_BYTE_W + PRIO_BYTE_W-1 -: PRIO_W] < ref_key))) begin
        ref_vld = 1'b1;
        ref_key = prio_i[i*PRIO_BYTE_W + PRIO_BYTE_W-1 -: PRIO_W];
        ref_id  = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok   <= 1'b0;
      ref_vld_q <= 1'b0;
      ref_key_q <= '0;
      ref_id_q  <= '0;
      grp_q     <= '0;
    end else begin
      past_ok   <= 1'b1;
      ref_vld_q <= ref_vld;
      ref_key_q <= ref_key;
      ref_id_q  <= ref_id;
      grp_q     <= grp_ctl_i;
    end
  end

  always_comb begin
    case (grp_q)
      3'd4:    sb_q = 3'd1;
      3'd5:    sb_q = 3'd2;
      3'd6:    sb_q = 3'd3;
      3'd7:    sb_q = 3'd4;
      default: sb_q = 3'd0;
    endcase
  end

  AST_VLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (win_vld_o == ref_vld_q)); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld_o |-> (win_id_o == '0 && win_grp_o == '0 && win_sub_o == '0)); // R1

  AST_BEST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && win_vld_o) |-> (win_id_o == ref_id_q)); // R4

  AST_FIELD_REBUILD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && win_vld_o) |-> ((PRIO_W'(win_grp_o << sb_q) | win_sub_o) == ref_key_q)); // R5

  AST_SUB_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((win_sub_o >> sb_q) == '0)); // R6

  AST_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_id_o < ID_W'(IRQ_CNT)); // R8
endmodule

bind prio_arb prio_arb_chk u_chk (.*);

// File: tb/test_prio_arb.sv
`timescale 1ns/1ps
module test_prio_arb;
  import prio_arb_pkg::*;

  typedef struct {
    bit    vld;
    int    id;
    int    grp;
    int    sub;
    string tag;
  } exp_t;

  logic                           clk;
  logic                           rst_n;
  logic [GRP_CTL_W-1:0]           grp_ctl_i;
  logic [IRQ_CNT-1:0]             irq_pend_i;
  logic [IRQ_CNT-1:0]             irq_en_i;
  logic [IRQ_CNT*PRIO_BYTE_W-1:0] prio_i;
  logic                           win_vld_o;
  logic [ID_W-1:0]                win_id_o;
  logic [PRIO_W-1:0]              win_grp_o;
  logic [PRIO_W-1:0]              win_sub_o;

  logic [7:0] tb_pb [IRQ_CNT];
  exp_t       sb_q [$];
  exp_t       prev_exp;
  int         n_chk;
  int         n_err;
  bit         done;

  prio_arb i_prio_arb (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < IRQ_CNT; i++) prio_i[i*8 +: 8] = tb_pb[i];
  end

  function automatic exp_t model(string tag);
    exp_t e;
    int   key;
    int   sb;
    e.vld = 0; e.id = 0; e.grp = 0; e.sub = 0; e.tag = tag;
    key = 16;
    for (int i = 0; i < IRQ_CNT; i++) begin
      if (irq_pend_i[i] && irq_en_i[i] && int'(tb_pb[i][7:4]) < key) begin
        key = int'(tb_pb[i][7:4]);
        e.id = i;
        e.vld = 1;
      end
    end
    if (e.vld) begin
      sb = (grp_ctl_i >= 4) ? int'(grp_ctl_i) - 3 : 0;
      e.grp = key >> sb;
      e.sub = key & ((1 << sb) - 1);
    end
    return e;
  endfunction

  task automatic compare(exp_t e, string what);
    n_chk++;
    if (win_vld_o !== e.vld || int'(win_id_o) != e.id ||
        int'(win_grp_o) != e.grp || int'(win_sub_o) != e.sub) begin
      n_err++;
      $display("FAIL %s %s: actual vld=%0d id=%0d grp=%0d sub=%0d expected vld=%0d id=%0d grp=%0d sub=%0d",
               e.tag, what, win_vld_o, win_id_o, win_grp_o, win_sub_o,
               e.vld, e.id, e.grp, e.sub);
    end
  endtask

  // driver: called just after a falling edge
  task automatic push(string tag);
    exp_t e;
    e = model(tag);
    sb_q.push_back(e);
    #1;
    prev_exp.tag = "R7";
    compare(prev_exp, "held before edge");
    prev_exp = e;
    @(negedge clk);
  endtask

  task automatic clear_in();
    irq_pend_i = '0;
    irq_en_i   = '0;
    grp_ctl_i  = '0;
    for (int i = 0; i < IRQ_CNT; i++) tb_pb[i] = 8'h00;
  endtask

  task automatic arm(int line, logic [7:0] pb);
    irq_pend_i[line] = 1'b1;
    irq_en_i[line]   = 1'b1;
    tb_pb[line]      = pb;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        #1;
        compare(e, "registered result");
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL R7 watchdog: actual run still busy expected finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    prev_exp = '{vld: 0, id: 0, grp: 0, sub: 0, tag: "R7"};
    clear_in();
    rst_n = 1'b0;
    irq_pend_i = '1; irq_en_i = '1;
    repeat (3) @(negedge clk);
    compare(prev_exp, "outputs during reset");
    clear_in();
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing enabled, then nothing pending
    irq_pend_i = '1;
    push("R1");
    irq_pend_i = '0; irq_en_i = '1;
    push("R1");
    // R1: a pending but disabled urgent line is skipped
    clear_in();
    irq_pend_i[0] = 1'b1; tb_pb[0] = 8'h00;
    arm(1, 8'hF0);
    push("R1");

    // R8: top line alone
    clear_in(); arm(67, 8'hF0);
    push("R8");

    // R2: lower group value beats lower line number
    clear_in(); grp_ctl_i = 3'd3;
    arm(5, 8'h90); arm(40, 8'h30);
    push("R2");
    grp_ctl_i = 3'd6;
    arm(7, 8'h10);
    push("R2");

    // R3: same group, lower subpriority wins (grouping 5: group 1)
    clear_in(); grp_ctl_i = 3'd5;
    arm(2, 8'h70); arm(50, 8'h50);
    push("R3");

    // R4: full tie goes to lowest line
    clear_in(); grp_ctl_i = 3'd4;
    arm(33, 8'h40); arm(20, 8'h40); arm(9, 8'h40);
    push("R4");
    irq_en_i = '1; irq_pend_i = '1;
    for (int i = 0; i < IRQ_CNT; i++) tb_pb[i] = 8'hA0;
    push("R4");

    // R5: low nibble ignored
    clear_in();
    arm(3, 8'h6F); arm(10, 8'h60);
    push("R5");
    clear_in();
    arm(1, 8'h2F); arm(0, 8'h30);
    push("R5");

    // R6: every grouping value on one line
    clear_in(); arm(12, 8'hB0);
    for (int g = 0; g < 8; g++) begin
      grp_ctl_i = 3'(g);
      push("R6");
    end

    // mixed patterns
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < IRQ_CNT; i++) begin
        irq_pend_i[i] = ($urandom % ((n % 3) * 4 + 2)) == 0;
        irq_en_i[i]   = ($urandom % 4) != 0;
        tb_pb[i]      = 8'($urandom);
      end
      grp_ctl_i = 3'($urandom);
      push("R2");
    end

    clear_in();
    push("R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule